// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block watches the stream of qualified write cycles going into a byte-wide flash array (one address and one data byte per cycle) and picks out multi-cycle unlock commands from it. Every command opens with the same two-cycle unlock prefix. After the prefix, one more cycle either finishes a short command or begins a longer six-cycle one. The decoded commands switch software write protection on or off, start a self-timed chip erase, and move the block into or out of product-identification mode.

Write cycles that are not part of a command pass through as ordinary data writes, but only when protection is off or when a page-load window is open. The short protection-on command opens that window. While identification mode is active, reads of address 0 and address 1 return fixed manufacturer and device codes instead of array data. A chip erase raises a one-cycle start strobe toward the array and then holds a busy flag for a parameter number of clock cycles. Plain writes are forwarded one cycle after they are sampled, on a registered write port that feeds the page buffer.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, protectOn is 1, while idMode, eraseBusy, eraseStart and dataWrEn are all 0.
- R2: Every command starts with data AAh at address 5555h and then data 55h at address 2AAAh. Only wrAddr[14:0] takes part in any command address match, so higher address bits are ignored.
- R3: The prefix followed by data A0h at 5555h sets protectOn and opens a page-load window. In the window, plain writes are accepted. The window closes once LOAD_IDLE clock cycles go by with no accepted write after the opening command or the last accepted write.
- R4: A plain write is forwarded when protectOn is 0 or the load window is open. It appears on dataWrEn, dataWrAddr and dataWrData for exactly the one cycle after the edge that samples it. In any other case it is discarded and dataWrEn stays 0.
- R5: The six-cycle sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clears protectOn.
- R6: The same six-cycle sequence ending in 10h@5555h pulses eraseStart for one cycle. It also holds eraseBusy high for exactly ERASE_CYCLES cycles, beginning the cycle after the final write. While eraseBusy is 1, every write cycle is ignored.
- R7: The six-cycle sequence ending in 60h@5555h sets idMode. The prefix followed by F0h@5555h clears it.
- R8: While idMode is 1, rdData is DAh at rdAddr 0 and C1h at rdAddr 1, and arrayRdData at any other address. While idMode is 0, rdData always equals arrayRdData.
- R9: A cycle that does not match the next expected command step sends the decoder back to idle. That cycle is then handled as a plain write under R4. Cycles that do match a command step are never forwarded.
- R10: A six-cycle sequence whose last byte is not 20h, 10h or 60h leaves protectOn, idMode and eraseBusy unchanged. Under R9, that last cycle is a plain write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | A qualified write cycle is present this cycle |
| wrAddr | input | ADDR_W | Write cycle address |
| wrData | input | 8 | Write cycle data |
| rdAddr | input | ADDR_W | Read address |
| arrayRdData | input | 8 | Data read from the array at rdAddr |
| rdData | output | 8 | Read data returned to the host |
| protectOn | output | 1 | Software write protection is active |
| idMode | output | 1 | Identification mode is active |
| eraseStart | output | 1 | One-cycle strobe that starts a chip erase (every byte to FFh) |
| eraseBusy | output | 1 | Chip erase is in progress |
| dataWrEn | output | 1 | Forwarded plain write strobe toward the page buffer |
| dataWrAddr | output | ADDR_W | Address of the forwarded write |
| dataWrData | output | 8 | Data of the forwarded write |

## Verification
The plain-write path is run in four situations: protected with no open window, protected inside an A0h window, protected after that window times out, and unprotected. Comparing them shows that acceptance depends on both the flag and the window. The command decoder is given full sequences with extra high address bits set, to show that only bits 14:0 are matched. It is also given a prefix broken by a stray cycle and a six-cycle sequence with an unknown last byte. These separate "reset to idle and forward the cycle" from "silently swallow it". Identification reads at addresses 0, 1 and 2, taken both inside and outside the mode, show the code substitution apart from the array pass-through. An erase run counts the busy cycles and sends a write into the busy window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [14:0] UNLOCK_ADDR_A = 15'h5555;
  localparam logic [14:0] UNLOCK_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_A         = 8'hAA;
  localparam logic [7:0]  KEY_B         = 8'h55;
  localparam logic [7:0]  OP_PROT_ON    = 8'hA0;
  localparam logic [7:0]  OP_EXTEND     = 8'h80;
  localparam logic [7:0]  OP_ID_EXIT    = 8'hF0;
  localparam logic [7:0]  OP_PROT_OFF   = 8'h20;
  localparam logic [7:0]  OP_ERASE      = 8'h10;
  localparam logic [7:0]  OP_ID_ENTER   = 8'h60;
  localparam logic [7:0]  MFR_CODE      = 8'hDA;
  localparam logic [7:0]  DEV_CODE      = 8'hC1;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_KEY1, SEQ_KEY2, SEQ_EXT3, SEQ_EXT4, SEQ_EXT5
  } seq_state_t;

  typedef struct packed {
    logic plainWrite;
    logic setProt;
    logic clrProt;
    logic startErase;
    logic enterId;
    logic exitId;
  } cmd_strobe_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  output cmd_strobe_t       strobe
);
  seq_state_t state, stateNext;
  logic       live;
  logic       atA, atB;

  assign live = wrValid && !busy;
  assign atA  = (wrAddr[14:0] == UNLOCK_ADDR_A);
  assign atB  = (wrAddr[14:0] == UNLOCK_ADDR_B);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (live) begin
      stateNext         = SEQ_IDLE;
      strobe.plainWrite = 1'b1;
      unique case (state)
        SEQ_IDLE: if (atA && wrData == KEY_A) begin
          stateNext = SEQ_KEY1; strobe.plainWrite = 1'b0;
        end
        SEQ_KEY1: if (atB && wrData == KEY_B) begin
          stateNext = SEQ_KEY2; strobe.plainWrite = 1'b0;
        end
        SEQ_KEY2: if (atA) begin
          if (wrData == OP_PROT_ON) begin
            strobe.setProt = 1'b1; strobe.plainWrite = 1'b0;
          end else if (wrData == OP_EXTEND) begin
            stateNext = SEQ_EXT3; strobe.plainWrite = 1'b0;
          end else if (wrData == OP_ID_EXIT) begin
            strobe.exitId = 1'b1; strobe.plainWrite = 1'b0;
          end
        end
        SEQ_EXT3: if (atA && wrData == KEY_A) begin
          stateNext = SEQ_EXT4; strobe.plainWrite = 1'b0;
        end
        SEQ_EXT4: if (atB && wrData == KEY_B) begin
          stateNext = SEQ_EXT5; strobe.plainWrite = 1'b0;
        end
        SEQ_EXT5: if (atA) begin
          if (wrData == OP_PROT_OFF) begin
            strobe.clrProt = 1'b1; strobe.plainWrite = 1'b0;
          end else if (wrData == OP_ERASE) begin
            strobe.startErase = 1'b1; strobe.plainWrite = 1'b0;
          end else if (wrData == OP_ID_ENTER) begin
            strobe.enterId = 1'b1; strobe.plainWrite = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int LOAD_IDLE    = 8,
  parameter int ERASE_CYCLES = 5_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmd_strobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        arrayRdData,
  output logic [7:0]        rdData,
  output logic              protectOn,
  output logic              idMode,
  output logic              eraseStart,
  output logic              eraseBusy,
  output logic              dataWrEn,
  output logic [ADDR_W-1:0] dataWrAddr,
  output logic [7:0]        dataWrData
);
  localparam int LOAD_W  = $clog2(LOAD_IDLE + 1);
  localparam int ERASE_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [LOAD_W-1:0]  LOAD_RELOAD  = LOAD_W'(LOAD_IDLE);
  localparam logic [ERASE_W-1:0] ERASE_RELOAD = ERASE_W'(ERASE_CYCLES);

  logic [LOAD_W-1:0]  loadCnt;
  logic [ERASE_W-1:0] eraseCnt;
  logic               loadOpen;
  logic               accept;

  assign loadOpen  = (loadCnt != '0);
  assign accept    = strobe.plainWrite && (!protectOn || loadOpen);
  assign eraseBusy = (eraseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protectOn <= 1'b1;
      idMode    <= 1'b0;
    end else begin
      if (strobe.setProt)      protectOn <= 1'b1;
      else if (strobe.clrProt) protectOn <= 1'b0;
      if (strobe.enterId)      idMode <= 1'b1;
      else if (strobe.exitId)  idMode <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       loadCnt <= '0;
    else if (strobe.setProt)         loadCnt <= LOAD_RELOAD;
    else if (accept && loadOpen)     loadCnt <= LOAD_RELOAD;
    else if (loadOpen)               loadCnt <= loadCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseCnt   <= '0;
      eraseStart <= 1'b0;
    end else begin
      eraseStart <= strobe.startErase;
      if (strobe.startErase) eraseCnt <= ERASE_RELOAD;
      else if (eraseBusy)    eraseCnt <= eraseCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataWrEn   <= 1'b0;
      dataWrAddr <= '0;
      dataWrData <= '0;
    end else begin
      dataWrEn <= accept;
      if (accept) begin
        dataWrAddr <= wrAddr;
        dataWrData <= wrData;
      end
    end
  end

  always_comb begin
    rdData = arrayRdData;
    if (idMode) begin
      if (rdAddr == ADDR_W'(0))      rdData = MFR_CODE;
      else if (rdAddr == ADDR_W'(1)) rdData = DEV_CODE;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int LOAD_IDLE    = 8,
  parameter int ERASE_CYCLES = 5_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        arrayRdData,
  output logic [7:0]        rdData,
  output logic              protectOn,
  output logic              idMode,
  output logic              eraseStart,
  output logic              eraseBusy,
  output logic              dataWrEn,
  output logic [ADDR_W-1:0] dataWrAddr,
  output logic [7:0]        dataWrData
);
  cmd_strobe_t strobe;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .busy(eraseBusy), .strobe(strobe)
  );

  flash_cmd_dpath #(
    .ADDR_W(ADDR_W), .LOAD_IDLE(LOAD_IDLE), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .arrayRdData(arrayRdData),
    .rdData(rdData), .protectOn(protectOn), .idMode(idMode),
    .eraseStart(eraseStart), .eraseBusy(eraseBusy), .dataWrEn(dataWrEn),
    .dataWrAddr(dataWrAddr), .dataWrData(dataWrData)
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic              protectOn,
  input logic              idMode,
  input logic              eraseStart,
  input logic              eraseBusy,
  input logic              dataWrEn
);
  // R5
  prot_clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protectOn) |-> $past(wrValid && wrData == 8'h20 && wrAddr[14:0] == 15'h5555));

  // R3
  prot_set_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protectOn) |-> $past(wrValid && wrData == 8'hA0 && wrAddr[14:0] == 15'h5555));

  // R6
  erase_begin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseBusy) |-> eraseStart);

  // R6
  erase_ignore_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn |-> !$past(eraseBusy));

  // R4
  fwd_needs_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWrEn |-> $past(wrValid));

  // R7
  id_enter_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idMode) |-> $past(wrValid && wrData == 8'h60 && wrAddr[14:0] == 15'h5555));

  // R8
  id_mfr_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idMode && rdAddr == ADDR_W'(0)) |-> rdData == 8'hDA);
endmodule

bind flash_cmd_decoder flash_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
  .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
  .protectOn(protectOn), .idMode(idMode), .eraseStart(eraseStart),
  .eraseBusy(eraseBusy), .dataWrEn(dataWrEn)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  localparam int AW = 17;
  localparam int LI = 8;
  localparam int EC = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    arrayRdData = 8'h3C;
  logic [7:0]    rdData;
  logic          protectOn, idMode, eraseStart, eraseBusy, dataWrEn;
  logic [AW-1:0] dataWrAddr;
  logic [7:0]    dataWrData;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [AW+7:0] expQ[$];

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .LOAD_IDLE(LI), .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .arrayRdData(arrayRdData),
    .rdData(rdData), .protectOn(protectOn), .idMode(idMode),
    .eraseStart(eraseStart), .eraseBusy(eraseBusy), .dataWrEn(dataWrEn),
    .dataWrAddr(dataWrAddr), .dataWrData(dataWrData)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every forwarded write must match the queue head (R4, R9)
  always @(negedge clk) begin
    if (rstN && dataWrEn && !done) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4 actual=%0h expected=none", {dataWrAddr, dataWrData});
      end else begin
        logic [AW+7:0] e;
        e = expQ.pop_front();
        if ({dataWrAddr, dataWrData} !== e) begin
          errors++;
          $display("FAIL R4 actual=%0h expected=%0h", {dataWrAddr, dataWrData}, e);
        end
      end
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, bit expectFwd);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    if (expectFwd) expQ.push_back({a, d});
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic prefix(logic [AW-1:0] hi);
    wr(hi | 17'h05555, 8'hAA, 0);
    wr(hi | 17'h02AAA, 8'h55, 0);
  endtask

  task automatic six(logic [7:0] last, bit fwdLast);
    prefix('0);
    wr(17'h05555, 8'h80, 0);
    prefix('0);
    wr(17'h05555, last, fwdLast);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(2);
    // R1 reset state
    chk("R1 protectOn", protectOn, 1);
    chk("R1 idMode", idMode, 0);
    chk("R1 eraseBusy", eraseBusy, 0);
    chk("R1 dataWrEn", dataWrEn, 0);
    rstN = 1'b1;
    idle(2);

    // R4: protected, no window -> discarded
    wr(17'h00100, 8'h11, 0);
    chk("R4 dropped while protected", dataWrEn, 0);

    // R3: A0h opens a window; writes accepted
    prefix('0);
    wr(17'h05555, 8'hA0, 0);
    chk("R3 protectOn after A0", protectOn, 1);
    wr(17'h00200, 8'h21, 1);
    chk("R3 window write forwarded", dataWrEn, 1);
    wr(17'h00201, 8'h22, 1);
    wr(17'h0027F, 8'h23, 1);
    // R3: window closes after LOAD_IDLE quiet cycles
    idle(LI + 3);
    wr(17'h00202, 8'h24, 0);
    chk("R3 window closed", dataWrEn, 0);

    // R5: six-cycle disable
    six(8'h20, 0);
    chk("R5 protectOn cleared", protectOn, 0);
    wr(17'h00300, 8'h31, 1);
    chk("R4 unprotected write forwarded", dataWrEn, 1);
    chk("R4 forwarded data", dataWrData, 8'h31);

    // R9: broken prefix -> stray cycle becomes plain write
    wr(17'h05555, 8'hAA, 0);
    chk("R9 command cycle not forwarded", dataWrEn, 0);
    wr(17'h00100, 8'h12, 1);
    chk("R9 mismatch forwarded", dataWrEn, 1);

    // R10: unknown final byte -> no mode change, last cycle is plain write
    six(8'h30, 1);
    chk("R10 protect unchanged", protectOn, 0);
    chk("R10 id unchanged", idMode, 0);
    chk("R10 busy unchanged", eraseBusy, 0);

    // R8: outside id mode reads pass through
    rdAddr = 17'd0; #1;
    chk("R8 array read at 0 outside id", rdData, 8'h3C);

    // R2 + R7: id entry with high address bits set (bits above 14 ignored)
    prefix(17'h18000);
    wr(17'h1D555, 8'h80, 0);
    prefix(17'h10000);
    wr(17'h15555, 8'h60, 0);
    chk("R2 R7 idMode entered via high-bit addresses", idMode, 1);
    rdAddr = 17'd0; #1;
    chk("R8 manufacturer code", rdData, 8'hDA);
    rdAddr = 17'd1; #1;
    chk("R8 device code", rdData, 8'hC1);
    rdAddr = 17'd2; #1;
    chk("R8 other address is array", rdData, 8'h3C);
    // R7 exit
    prefix('0);
    wr(17'h05555, 8'hF0, 0);
    chk("R7 idMode exit", idMode, 0);
    rdAddr = 17'd1; #1;
    chk("R8 array read after exit", rdData, 8'h3C);

    // R6: chip erase
    six(8'h10, 0);
    chk("R6 eraseStart pulse", eraseStart, 1);
    chk("R6 eraseBusy set", eraseBusy, 1);
    begin
      int n;
      n = 0;
      while (eraseBusy && n < 10 * EC) begin
        n++;
        if (n == 3) begin
          wrValid = 1'b1; wrAddr = 17'h00400; wrData = 8'h44;
        end
        if (n == 4) begin
          wrValid = 1'b0;
          chk("R6 eraseStart one cycle", eraseStart, 0);
        end
        if (n == 5) chk("R6 write ignored while busy", dataWrEn, 0);
        @(negedge clk);
      end
      chk("R6 busy length", n, EC);
    end
    chk("R6 protect unchanged by erase", protectOn, 0);

    // R4 after erase: unprotected write works again
    wr(17'h00500, 8'h55, 1);
    chk("R4 write after erase", dataWrEn, 1);

    idle(3);
    chk("R4 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule